// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether each incoming frame is kept or dropped, using only the 48-bit destination address. The first six bytes of a frame arrive one byte per valid cycle. The first byte is marked by a start strobe. While the bytes arrive, the block captures the address and runs a byte-wide reflected CRC-32 over it. In the cycle after the sixth byte it presents a one-cycle decision pulse.

The decision follows a set of configuration registers, which are written through simple write-enable ports:
- five mode bits;
- two 32-bit words that together form a 64-bit multicast hash table;
- a bank of address slots.

Slot 0 holds the station's own address and is always compared. The slots numbered from 1 upward are perfect-match entries, and each one has its own enable. A parameter sets how many of these slots exist: 16 in the base build, 32 in the extended build.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame begins with the byte presented with `byteValid` and `byteStart` both high. The next five `byteValid` bytes complete the address. Byte i (0 = first) forms address bits [8i+7:8i]. Further `byteValid` bytes without `byteStart` are ignored until the next start.
- R2: `decValid` pulses high for exactly one cycle, in the cycle after the sixth address byte is taken. A frame produces exactly one pulse. `decAccept` is low whenever `decValid` is low.
- R3: With mode bit 0 (promiscuous) set, every frame is accepted.
- R4: With mode bit 1 (receive-all) set, every frame is accepted.
- R5: The all-ones broadcast address is accepted unless mode bit 4 (broadcast disable) is set. Bits 0 and 1 override this rule.
- R6: A multicast frame (bit 0 of the first byte is 1, not broadcast) is accepted when mode bit 2 (pass-all-multicast) is set.
- R7: With mode bit 3 (hash enable) set, a multicast frame is accepted when the hash-table bit at its index is 1. The index is computed as follows:
  - Run the reflected CRC-32 (polynomial 0x04C11DB7, LSB of each byte first) over the six bytes, starting from all ones.
  - Complement the result and bit-reverse it.
  - Keep the top 6 bits as the index.

  Index bit 5 selects the word (1 = high, `hashSel`=1; 0 = low). Index bits 4:0 select the bit in that word. Two all-ones words pass every multicast frame.
- R8: A multicast frame is dropped when neither bit 2 nor a matching hash bit applies. The hash and pass-all bits never accept a unicast frame.
- R9: A unicast frame equal to slot 0 is accepted whatever the enable bit written with slot 0.
- R10: A unicast frame equal to slot k (1 ≤ k ≤ 16 in the base build, 32 extended) is accepted only if slot k's enable is set. Writes to slot indices beyond the last slot are ignored.
- R11: A unicast frame that matches no active slot is dropped when bits 0 and 1 are clear.
- R12: After reset, `decValid` is low, all mode bits and hash words are zero, and all slots are zero and disabled.
- R13: A `byteStart` during a partly received address restarts the capture from byte 0. The abandoned address produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Address byte present on `byteData` |
| byteStart | input | 1 | Marks the first byte of a frame (with `byteValid`) |
| byteData | input | 8 | Destination address byte |
| cfgModeWe | input | 1 | Write strobe for the mode bits |
| cfgModeData | input | 5 | Mode bits: 0 promiscuous, 1 receive-all, 2 pass-all-multicast, 3 hash enable, 4 broadcast disable |
| hashWe | input | 1 | Write strobe for a hash word |
| hashSel | input | 1 | 1 = high hash word, 0 = low |
| hashData | input | 32 | Hash word value |
| slotWe | input | 1 | Write strobe for an address slot |
| slotIdx | input | 6 | Slot number (0 = station address) |
| slotAddr | input | 48 | Slot address, first received byte in bits 7:0 |
| slotEn | input | 1 | Enable for the written slot (ignored for slot 0) |
| decValid | output | 1 | Decision pulse |
| decAccept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The assertions assume that `byteStart` is only meaningful together with `byteValid`. They also assume that the mode bits seen by a decision are the ones held in the cycle that carried the sixth byte. A mode write in that same cycle therefore counts toward the following frame.

The stimulus follows the same rules. It drives every input on the falling edge and finishes each configuration write before the next frame starts. It applies `byteStart` only together with `byteValid`. It uses idle gaps between bytes and a deliberately abandoned partial address to exercise the counting without breaking these assumptions.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int SLOT_IDX_W = 6;
  localparam int MODE_W = 5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // bit 4 .. bit 0 of cfgModeData
  typedef struct packed {
    logic bcastDis;
    logic hashMcEn;
    logic passAllMc;
    logic rxAll;
    logic promisc;
  } rxafMode_t;

  // control to datapath strobes
  typedef struct packed {
    logic take;
    logic first;
    logic last;
    logic [2:0] pos;
  } rxafStrobe_t;

  function automatic logic [31:0] crcByte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      r = (r[0] ^ d[k]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteStart,
  output rxafStrobe_t strb
);
  localparam logic [2:0] LAST_POS = 3'(ADDR_BYTES - 1);

  logic [2:0] cnt;
  logic       active;

  always_comb begin
    strb.first = byteValid & byteStart;
    strb.take  = byteValid & (byteStart | active);
    strb.pos   = byteStart ? 3'd0 : cnt;
    strb.last  = strb.take & (strb.pos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (strb.take) begin
      cnt    <= strb.pos + 3'd1;
      active <= !strb.last;
    end
  end
endmodule

// File: rtl/rxaf_datapath.sv
module rxaf_datapath
  import rxaf_pkg::*;
#(
  parameter int PERFECT_SLOTS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rxafStrobe_t           strb,
  input  logic [7:0]            byteData,
  input  logic                  cfgModeWe,
  input  logic [MODE_W-1:0]     cfgModeData,
  input  logic                  hashWe,
  input  logic                  hashSel,
  input  logic [31:0]           hashData,
  input  logic                  slotWe,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  input  logic [ADDR_W-1:0]     slotAddr,
  input  logic                  slotEn,
  output logic                  decValid,
  output logic                  decAccept
);
  localparam int TOTAL_SLOTS = PERFECT_SLOTS + 1;
  localparam int HELD_W = ADDR_W - 8;

  rxafMode_t          modeQ;
  logic [31:0]        hashLo, hashHi;
  logic [HELD_W-1:0]  addrQ;
  logic [31:0]        crcQ, crcSeed, crcNext;
  logic [ADDR_W-1:0]  fullAddr;
  logic [5:0]         hashIdx;
  logic [31:0]        hashWord;
  logic               hashBit, isMc, isBc, acceptNext;
  logic [TOTAL_SLOTS-1:0] hit;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      hashLo <= '0;
      hashHi <= '0;
    end else begin
      if (cfgModeWe) modeQ <= rxafMode_t'(cfgModeData);
      if (hashWe && hashSel)  hashHi <= hashData;
      if (hashWe && !hashSel) hashLo <= hashData;
    end
  end

  // address capture and running CRC
  assign crcSeed = strb.first ? '1 : crcQ;
  assign crcNext = crcByte(crcSeed, byteData);
  assign fullAddr = {byteData, addrQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      crcQ  <= '1;
    end else if (strb.take) begin
      crcQ <= crcNext;
      for (int k = 0; k < ADDR_BYTES - 1; k++) begin
        if (strb.pos == 3'(k)) addrQ[8*k +: 8] <= byteData;
      end
    end
  end

  // hash index: upper bits of bit-reversed complement
  always_comb begin
    for (int j = 0; j < 6; j++) hashIdx[5-j] = ~crcNext[j];
  end
  assign hashWord = hashIdx[5] ? hashHi : hashLo;
  assign hashBit  = hashWord[hashIdx[4:0]];

  // perfect address bank
  for (genvar s = 0; s < TOTAL_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] slotQ;
    logic              enQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
        enQ   <= 1'b0;
      end else if (slotWe && slotIdx == SLOT_IDX_W'(s)) begin
        slotQ <= slotAddr;
        enQ   <= slotEn;
      end
    end
    if (s == 0) begin : g_own
      assign hit[s] = (slotQ == fullAddr);
    end else begin : g_perfect
      assign hit[s] = enQ && (slotQ == fullAddr);
    end
  end

  assign isBc = &fullAddr;
  assign isMc = fullAddr[0];

  always_comb begin
    if (modeQ.promisc || modeQ.rxAll) acceptNext = 1'b1;
    else if (isBc)                    acceptNext = !modeQ.bcastDis;
    else if (isMc)                    acceptNext = modeQ.passAllMc || (modeQ.hashMcEn && hashBit);
    else                              acceptNext = |hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= strb.last;
      decAccept <= strb.last && acceptNext;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter bit EXT_SLOTS = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic                  byteStart,
  input  logic [7:0]            byteData,
  input  logic                  cfgModeWe,
  input  logic [MODE_W-1:0]     cfgModeData,
  input  logic                  hashWe,
  input  logic                  hashSel,
  input  logic [31:0]           hashData,
  input  logic                  slotWe,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  input  logic [ADDR_W-1:0]     slotAddr,
  input  logic                  slotEn,
  output logic                  decValid,
  output logic                  decAccept
);
  localparam int PERFECT_SLOTS = EXT_SLOTS ? 32 : 16;

  rxafStrobe_t strb;

  rxaf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteStart(byteStart), .strb(strb)
  );

  rxaf_datapath #(.PERFECT_SLOTS(PERFECT_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .cfgModeWe(cfgModeWe), .cfgModeData(cfgModeData),
    .hashWe(hashWe), .hashSel(hashSel), .hashData(hashData),
    .slotWe(slotWe), .slotIdx(slotIdx), .slotAddr(slotAddr), .slotEn(slotEn),
    .decValid(decValid), .decAccept(decAccept)
  );
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker
  import rxaf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic              byteStart,
  input logic              cfgModeWe,
  input logic [MODE_W-1:0] cfgModeData,
  input logic              decValid,
  input logic              decAccept
);
  logic [2:0]        chkCnt;
  logic              chkActive;
  logic [MODE_W-1:0] modeShadow;
  logic              sixthSeen;

  assign sixthSeen = byteValid && !byteStart && chkActive && (chkCnt == 3'(ADDR_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt     <= '0;
      chkActive  <= 1'b0;
      modeShadow <= '0;
    end else begin
      if (cfgModeWe) modeShadow <= cfgModeData;
      if (byteValid && byteStart) begin
        chkCnt    <= 3'd1;
        chkActive <= 1'b1;
      end else if (byteValid && chkActive) begin
        chkCnt    <= chkCnt + 3'd1;
        chkActive <= !sixthSeen;
      end
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);
  p_pulse_follows_sixth_r2: assert property (@(posedge clk) disable iff (!rstN)
    sixthSeen |=> decValid);
  p_no_spurious_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(sixthSeen));
  p_accept_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !decAccept);
  p_promisc_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(modeShadow[0])) |-> decAccept);
  p_rxall_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(modeShadow[1])) |-> decAccept);
endmodule

bind rx_addr_filter rxaf_checker u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteStart(byteStart),
  .cfgModeWe(cfgModeWe), .cfgModeData(cfgModeData),
  .decValid(decValid), .decAccept(decAccept)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0, byteStart = 1'b0;
  logic [7:0]  byteData = '0;
  logic        cfgModeWe = 1'b0;
  logic [4:0]  cfgModeData = '0;
  logic        hashWe = 1'b0, hashSel = 1'b0;
  logic [31:0] hashData = '0;
  logic        slotWe = 1'b0, slotEn = 1'b0;
  logic [5:0]  slotIdx = '0;
  logic [47:0] slotAddr = '0;
  logic        decValid, decAccept;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter dut (.*);

  always @(negedge clk) if (decValid) pulses++;

  localparam logic [47:0] OWN   = 48'h665544332210;
  localparam logic [47:0] S1    = 48'h0000BEEF0002;
  localparam logic [47:0] S2    = 48'h00000000CA04;
  localparam logic [47:0] S16   = 48'h0A0B0C0D0E06;
  localparam logic [47:0] S17   = 48'h0A0B0C0D0E08;
  localparam logic [47:0] UNI   = 48'h123456789A0C;
  localparam logic [47:0] BC    = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC    = 48'h665544332211;

  // {mode, address, expected accept}
  localparam logic [53:0] VEC [15] = '{
    {5'h00, OWN, 1'b1},   // R9
    {5'h00, S1,  1'b1},   // R10
    {5'h00, S2,  1'b0},   // R10 disabled slot
    {5'h00, S16, 1'b1},   // R10 last base slot
    {5'h00, S17, 1'b0},   // R10 out-of-range write ignored
    {5'h00, UNI, 1'b0},   // R11
    {5'h00, BC,  1'b1},   // R5
    {5'h10, BC,  1'b0},   // R5 disabled
    {5'h00, MC,  1'b0},   // R8
    {5'h04, MC,  1'b1},   // R6
    {5'h01, UNI, 1'b1},   // R3
    {5'h02, UNI, 1'b1},   // R4
    {5'h11, BC,  1'b1},   // R3 overrides broadcast disable
    {5'h08, MC,  1'b0},   // R7 empty table
    {5'h04, UNI, 1'b0}    // R8 pass-all ignores unicast
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic writeMode(logic [4:0] m);
    @(negedge clk); cfgModeWe = 1'b1; cfgModeData = m;
    @(negedge clk); cfgModeWe = 1'b0;
  endtask

  task automatic writeHash(logic sel, logic [31:0] d);
    @(negedge clk); hashWe = 1'b1; hashSel = sel; hashData = d;
    @(negedge clk); hashWe = 1'b0;
  endtask

  task automatic writeSlot(logic [5:0] i, logic [47:0] a, logic en);
    @(negedge clk); slotWe = 1'b1; slotIdx = i; slotAddr = a; slotEn = en;
    @(negedge clk); slotWe = 1'b0;
  endtask

  // sends six bytes; samples the decision one cycle after the sixth
  task automatic runFrame(logic [47:0] a, int gap, output logic v, output logic acc, output logic v2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteStart = (i == 0); byteData = a[8*i +: 8];
      if (gap > 0 && i < 5) begin
        @(negedge clk); byteValid = 1'b0; byteStart = 1'b0;
      end
    end
    @(negedge clk); byteValid = 1'b0; byteStart = 1'b0;
    v = decValid; acc = decAccept;
    @(negedge clk); v2 = decValid;
  endtask

  function automatic logic [5:0] hashIndex(logic [47:0] a);
    logic [31:0] c, r, rev;
    c = '1;
    for (int b = 0; b < 48; b++) begin
      if (c[0] ^ a[b]) c = (c >> 1) ^ 32'hEDB88320; else c = c >> 1;
    end
    r = ~c;
    for (int k = 0; k < 32; k++) rev[31-k] = r[k];
    return rev[31:26];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, acc, v2;
    logic [5:0] idx;
    int p0;
    repeat (3) @(negedge clk);
    check("R12 decValid in reset", decValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 decValid after reset", decValid, 1'b0);
    runFrame(BC, 0, v, acc, v2);
    check("R12 broadcast kept with cleared mode", acc, 1'b1);
    runFrame(MC, 0, v, acc, v2);
    check("R12 multicast dropped with cleared mode", acc, 1'b0);

    writeSlot(6'd0, OWN, 1'b0);
    writeSlot(6'd1, S1, 1'b1);
    writeSlot(6'd2, S2, 1'b0);
    writeSlot(6'd16, S16, 1'b1);
    writeSlot(6'd17, S17, 1'b1);

    foreach (VEC[n]) begin
      writeMode(VEC[n][53:49]);
      runFrame(VEC[n][48:1], n % 2, v, acc, v2);
      check($sformatf("R2 vector %0d valid", n), v, 1'b1);
      check($sformatf("R2 vector %0d pulse ends", n), v2, 1'b0);
      check($sformatf("R3-R11 vector %0d accept", n), acc, VEC[n][0]);
    end

    // R7 hash selection
    idx = hashIndex(MC);
    writeMode(5'h08);
    writeHash(idx[5], 32'h1 << idx[4:0]);
    writeHash(!idx[5], 32'h0);
    runFrame(MC, 0, v, acc, v2);
    check("R7 hash bit set accepts", acc, 1'b1);
    writeHash(idx[5], 32'h0);
    writeHash(!idx[5], 32'h1 << idx[4:0]);
    runFrame(MC, 0, v, acc, v2);
    check("R7 word select by index bit 5", acc, 1'b0);
    writeHash(1'b0, '1);
    writeHash(1'b1, '1);
    runFrame(48'h0000005E0001, 0, v, acc, v2);
    check("R7 all-ones table passes multicast", acc, 1'b1);
    runFrame(UNI, 0, v, acc, v2);
    check("R8 hash ignores unicast", acc, 1'b0);

    // R13 restart mid-address
    writeMode(5'h00);
    p0 = pulses;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byteValid = 1'b1; byteStart = (i == 0); byteData = 8'h11;
    end
    runFrame(S1, 0, v, acc, v2);
    check("R13 restart accept", acc, 1'b1);
    check("R13 single pulse", logic'(pulses - p0 == 1), 1'b1);

    // R1 trailing bytes ignored
    p0 = pulses;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byteValid = 1'b1; byteStart = 1'b0; byteData = 8'hFF;
    end
    @(negedge clk); byteValid = 1'b0;
    @(negedge clk);
    check("R1 trailing bytes give no decision", logic'(pulses == p0), 1'b1);
    runFrame(OWN, 0, v, acc, v2);
    check("R1 next frame after trailing bytes", acc, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule